// File: doc/BRIEF.md
# Processor Status Flags with Interrupt Save and Restore

This block keeps the status byte of a small 8-bit processor core. Condition bits are loaded from the ALU result under separate per-flag enables. Two stack-status bits are sticky and read-only. A trap bit and a global interrupt enable bit are under program control. A second byte, the shadow copy, captures the status when an interrupt is entered. When the interrupt returns, the status is reloaded from the shadow copy, except for the two sticky stack bits, which keep their current values.

Both bytes sit in the core's register file. Software reads and writes them there through a single-cycle access port, so a task switcher can save and replace the shadow copy. The read path is combinational. All updates take effect on the next rising clock edge. The ALU, the stack memory and the interrupt controller are outside this block. The block sees only their result and strobes.

Status layout, from bit 7 down to bit 0: carry, zero, sign, trap, stack overflow, stack full, always 0, global interrupt enable. The shadow copy uses the same positions, with bits 3 to 1 always reading 0.

Top module: `cpu_status_flags`

## Requirements
- R1: After reset, both the status byte (address 0xFF) and the shadow copy (address 0xCF) read 0x00, and `gie` is 0.
- R2: When `upd_zero` is 1, the zero flag (bit 6) becomes 1 if `alu_result` is all zeros and becomes 0 otherwise.
- R3: When `upd_sign` is 1, the sign flag (bit 5) takes the most significant bit of `alu_result`.
- R4: The carry flag (bit 7) is loaded from `alu_carry` only when `upd_carry` is 1. A flag whose enable is 0 keeps its value.
- R5: A write to 0xFF loads bits 7, 6, 5, 4 and 0 from the write data. Bits 3 and 2 are unaffected by the write, and bit 1 always reads 0.
- R6: If a write to 0xFF and an ALU flag update happen in the same cycle, the written value wins.
- R7: A `stk_wrap` pulse sets bit 3 and a `stk_full_evt` pulse sets bit 2. Once set, each bit stays set until reset. This holds even when a write of 0 to 0xFF happens in the same cycle or later.
- R8: The shadow copy at 0xCF is readable and writable. Bits 3 to 1 of a write are discarded, and those bits read 0.
- R9: On `irq_enter`, the shadow copy receives the current status with bits 3 to 1 forced to 0. In the same edge, the global interrupt enable bit is cleared.
- R10: On `irq_return` without `irq_enter`, bits 7, 6, 5, 4 and 0 are reloaded from the shadow copy. Bits 3 and 2 are unchanged.
- R11: When `irq_enter` coincides with a write to 0xCF, the save wins. When it coincides with a write to 0xFF, the enable bit still ends up 0.
- R12: A read from any address other than 0xFF and 0xCF returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_result | input | RES_W | Result of the current ALU operation |
| alu_carry | input | 1 | Carry-out of the current ALU operation |
| upd_carry | input | 1 | Load carry flag from `alu_carry` |
| upd_zero | input | 1 | Load zero flag from the result |
| upd_sign | input | 1 | Load sign flag from the result |
| stk_wrap | input | 1 | Stack pointer wrapped (sets overflow) |
| stk_full_evt | input | 1 | Stack became full (sets full) |
| irq_enter | input | 1 | Interrupt is being taken |
| irq_return | input | 1 | Return from interrupt |
| reg_addr | input | ADDR_W | Register-file address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| flags_q | output | 8 | Current status byte |
| gie | output | 1 | Global interrupt enable |

## Verification
The hardest situation to reach is an interrupt return that happens after both sticky stack bits have been set and the shadow copy holds different arithmetic bits from the live status. Only in that situation does a full-byte restore differ from a restore that leaves bits 3 and 2 alone. The stimulus reaches it in steps:
- It raises both stack strobes, one of them while writing 0 to the status byte.
- It loads a known status and takes an interrupt.
- It overwrites the live status.
- It issues the return and compares the whole byte.

Coincident strobes, such as a save and a shadow write in the same cycle, are driven deliberately to pin down each priority.

// File: rtl/stflag_pkg.sv
package stflag_pkg;

   localparam int STAT_W   = 8;
   localparam int B_CARRY  = 7;
   localparam int B_ZERO   = 6;
   localparam int B_SIGN   = 5;
   localparam int B_TRAP   = 4;
   localparam int B_OVF    = 3;
   localparam int B_FULL   = 2;
   localparam int B_GIE    = 0;
   localparam int N_STICKY = 2;

   // bits software and the shadow copy may carry
   localparam logic [STAT_W-1:0] LIVE_MASK = 8'hF1;
   // bits fed from the sticky stack tracker
   localparam logic [STAT_W-1:0] STICKY_MASK = 8'h0C;

   typedef struct packed {
      logic carry;
      logic zero;
      logic sign;
      logic trap;
      logic ovf;
      logic full;
      logic rsvd;
      logic gie;
   } stat_t;

endpackage

// File: rtl/stflag_alu_eval.sv
module stflag_alu_eval #(
   parameter int RES_W = 8
) (
   input  logic [RES_W-1:0] result,
   output logic             is_zero,
   output logic             is_neg
);
   localparam int MSB = RES_W - 1;

   generate
      if (RES_W < 1) begin : g_bad_width
         $error("stflag_alu_eval: RES_W must be at least 1");
      end
   endgenerate

   assign is_zero = (result == '0);
   assign is_neg  = result[MSB];

endmodule

// File: rtl/stflag_sticky.sv
module stflag_sticky #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   output logic [N-1:0] q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("stflag_sticky: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= 1'b0;
            else if (set[i])
               q[i] <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/stflag_hold.sv
module stflag_hold #(
   parameter int          W         = 8,
   parameter logic [W-1:0] KEEP_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         save,
   input  logic [W-1:0] save_val,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] hold_q
);
   logic [W-1:0] unused_dropped;
   assign unused_dropped = (save_val | wdata) & ~KEEP_MASK;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (KEEP_MASK[i]) begin : g_kept
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  hold_q[i] <= 1'b0;
               else if (save)
                  hold_q[i] <= save_val[i];
               else if (wr)
                  hold_q[i] <= wdata[i];
            end
         end else begin : g_zero
            assign hold_q[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/cpu_status_flags.sv
module cpu_status_flags
   import stflag_pkg::*;
#(
   parameter int               RES_W      = 8,
   parameter int               ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] FLAGS_ADDR = 8'hFF,
   parameter logic [ADDR_W-1:0] HOLD_ADDR  = 8'hCF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RES_W-1:0]  alu_result,
   input  logic              alu_carry,
   input  logic              upd_carry,
   input  logic              upd_zero,
   input  logic              upd_sign,
   input  logic              stk_wrap,
   input  logic              stk_full_evt,
   input  logic              irq_enter,
   input  logic              irq_return,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [7:0]        flags_q,
   output logic              gie
);
   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("cpu_status_flags: ADDR_W must be at least 1");
      end
      if (FLAGS_ADDR == HOLD_ADDR) begin : g_bad_map
         $error("cpu_status_flags: status and shadow addresses must differ");
      end
   endgenerate

   logic         sel_flags, sel_hold, wr_flags, wr_hold, ret_eff;
   logic         res_zero, res_neg;
   logic [N_STICKY-1:0] stk_set, stk_q;
   logic [7:0]   hold_q;
   stat_t        live_q, live_d, stat_now;

   assign sel_flags = (reg_addr == FLAGS_ADDR);
   assign sel_hold  = (reg_addr == HOLD_ADDR);
   assign wr_flags  = reg_wr & sel_flags;
   assign wr_hold   = reg_wr & sel_hold;
   assign ret_eff   = irq_return & ~irq_enter;

   stflag_alu_eval #(.RES_W(RES_W)) u_eval (
      .result  (alu_result),
      .is_zero (res_zero),
      .is_neg  (res_neg)
   );

   // index 1 -> overflow, index 0 -> full
   assign stk_set = {stk_wrap, stk_full_evt};

   stflag_sticky #(.N(N_STICKY)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (stk_set),
      .q     (stk_q)
   );

   always_comb begin
      stat_now      = live_q;
      stat_now.ovf  = stk_q[1];
      stat_now.full = stk_q[0];
      stat_now.rsvd = 1'b0;
   end

   stflag_hold #(.W(STAT_W), .KEEP_MASK(LIVE_MASK)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .save     (irq_enter),
      .save_val (stat_now),
      .wr       (wr_hold),
      .wdata    (reg_wdata),
      .hold_q   (hold_q)
   );

   // live bit update: return restore > software write > ALU; entry clears enable
   always_comb begin
      live_d = live_q;
      if (upd_carry) live_d.carry = alu_carry;
      if (upd_zero)  live_d.zero  = res_zero;
      if (upd_sign)  live_d.sign  = res_neg;
      if (wr_flags) begin
         live_d.carry = reg_wdata[B_CARRY];
         live_d.zero  = reg_wdata[B_ZERO];
         live_d.sign  = reg_wdata[B_SIGN];
         live_d.trap  = reg_wdata[B_TRAP];
         live_d.gie   = reg_wdata[B_GIE];
      end
      if (ret_eff) begin
         live_d.carry = hold_q[B_CARRY];
         live_d.zero  = hold_q[B_ZERO];
         live_d.sign  = hold_q[B_SIGN];
         live_d.trap  = hold_q[B_TRAP];
         live_d.gie   = hold_q[B_GIE];
      end
      if (irq_enter) live_d.gie = 1'b0;
      live_d.ovf  = 1'b0;
      live_d.full = 1'b0;
      live_d.rsvd = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         live_q <= '0;
      else
         live_q <= live_d;
   end

   always_comb begin
      if (sel_flags)
         reg_rdata = stat_now;
      else if (sel_hold)
         reg_rdata = hold_q;
      else
         reg_rdata = 8'h00;
   end

   assign flags_q = stat_now;
   assign gie     = stat_now.gie;

endmodule

// File: rtl/stflag_checker.sv
module stflag_checker #(
   parameter int               RES_W      = 8,
   parameter int               ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] FLAGS_ADDR = 8'hFF,
   parameter logic [ADDR_W-1:0] HOLD_ADDR  = 8'hCF
) (
   input logic              clk,
   input logic              rst_n,
   input logic [RES_W-1:0]  alu_result,
   input logic              alu_carry,
   input logic              upd_carry,
   input logic              upd_zero,
   input logic              stk_wrap,
   input logic              stk_full_evt,
   input logic              irq_enter,
   input logic              irq_return,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [7:0]        reg_rdata,
   input logic [7:0]        flags_q,
   input logic              gie,
   input logic [7:0]        hold_q
);
   logic sw_flags, quiet;
   assign sw_flags = reg_wr && (reg_addr == FLAGS_ADDR);
   assign quiet    = !sw_flags && !irq_return;

   AST_OVF_STICKS: assert property (@(posedge clk) disable iff (!rst_n) flags_q[3] |=> flags_q[3]); // R7
   AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n) flags_q[2] |=> flags_q[2]); // R7
   AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n) stk_wrap |=> flags_q[3]); // R7
   AST_FULL_SETS: assert property (@(posedge clk) disable iff (!rst_n) stk_full_evt |=> flags_q[2]); // R7
   AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (upd_zero && quiet) |=> (flags_q[6] == ($past(alu_result) == '0))); // R2
   AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (upd_carry && quiet) |=> (flags_q[7] == $past(alu_carry))); // R4
   AST_BIT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n) flags_q[1] == 1'b0); // R5
   AST_HOLD_RSVD: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr == HOLD_ADDR) |-> (reg_rdata[3:1] == 3'b000)); // R8
   AST_ENTRY_GIE: assert property (@(posedge clk) disable iff (!rst_n) irq_enter |=> !gie); // R9
   AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n) irq_enter |=> (hold_q == ($past(flags_q) & 8'hF1))); // R9
   AST_RET_KEEPS_STK: assert property (@(posedge clk) disable iff (!rst_n) (irq_return && !irq_enter && !stk_wrap && !stk_full_evt) |=> (flags_q[3:2] == $past(flags_q[3:2]))); // R10

endmodule

bind cpu_status_flags stflag_checker #(
   .RES_W(RES_W), .ADDR_W(ADDR_W), .FLAGS_ADDR(FLAGS_ADDR), .HOLD_ADDR(HOLD_ADDR)
) u_chk (.*);

// File: tb/cpu_status_flags_tb.sv
module cpu_status_flags_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] alu_result = '0;
   logic       alu_carry = 1'b0, upd_carry = 1'b0, upd_zero = 1'b0, upd_sign = 1'b0;
   logic       stk_wrap = 1'b0, stk_full_evt = 1'b0, irq_enter = 1'b0, irq_return = 1'b0;
   logic [7:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata, flags_q;
   logic       gie;

   int n_chk = 0, n_bad = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   cpu_status_flags u_dut (
      .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
      .upd_carry(upd_carry), .upd_zero(upd_zero), .upd_sign(upd_sign),
      .stk_wrap(stk_wrap), .stk_full_evt(stk_full_evt), .irq_enter(irq_enter),
      .irq_return(irq_return), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flags_q(flags_q), .gie(gie)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic idle();
      upd_carry = 0; upd_zero = 0; upd_sign = 0; stk_wrap = 0; stk_full_evt = 0;
      irq_enter = 0; irq_return = 0; reg_wr = 0;
   endtask

   task automatic tick();
      @(posedge clk); #1; idle();
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1; tick();
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(8'hFF, d); check("R1 status", d, 8'h00);
      rd(8'hCF, d); check("R1 shadow", d, 8'h00);
      check("R1 gie", {7'b0, gie}, 8'h00);
   endtask

   task automatic t_alu();
      alu_result = 8'h00; upd_zero = 1; upd_sign = 1; tick();
      check("R2 zero on 0", flags_q, 8'h40);
      alu_result = 8'h80; upd_zero = 1; upd_sign = 1; tick();
      check("R3 sign on msb", flags_q, 8'h20);
      alu_result = 8'h01; upd_sign = 1; tick();
      check("R3 sign clear", flags_q, 8'h00);
      alu_carry = 1; upd_carry = 1; tick();
      check("R4 carry load", flags_q, 8'h80);
      alu_carry = 0; alu_result = 8'h00; tick();
      check("R4 no enable keeps", flags_q, 8'h80);
      alu_carry = 0; upd_carry = 1; tick();
      check("R4 carry clear", flags_q, 8'h00);
   endtask

   task automatic t_swwrite();
      logic [7:0] d;
      wr(8'hFF, 8'hFF); rd(8'hFF, d); check("R5 write all ones", d, 8'hF1);
      wr(8'hFF, 8'h10); rd(8'hFF, d); check("R5 trap only", d, 8'h10);
      wr(8'hFF, 8'h00); rd(8'hFF, d); check("R5 clear", d, 8'h00);
   endtask

   task automatic t_priority();
      alu_result = 8'h05; alu_carry = 0; upd_carry = 1; upd_zero = 1; upd_sign = 1;
      wr(8'hFF, 8'hC0);
      check("R6 write beats ALU", flags_q, 8'hC0);
      wr(8'hFF, 8'h00);
   endtask

   task automatic t_sticky();
      logic [7:0] d;
      stk_wrap = 1; tick();
      check("R7 overflow set", flags_q, 8'h08);
      stk_full_evt = 1; wr(8'hFF, 8'h00);
      rd(8'hFF, d); check("R7 full set with write", d, 8'h0C);
      wr(8'hFF, 8'h00); tick();
      rd(8'hFF, d); check("R7 stays after write", d, 8'h0C);
   endtask

   task automatic t_hold();
      logic [7:0] d;
      wr(8'hCF, 8'hFF); rd(8'hCF, d); check("R8 shadow write", d, 8'hF1);
      wr(8'hCF, 8'h0E); rd(8'hCF, d); check("R8 reserved dropped", d, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(8'hFF, 8'hB1);
      check("R5 status loaded", flags_q, 8'hBD);
      irq_enter = 1; tick();
      rd(8'hCF, d); check("R9 shadow saved", d, 8'hB1);
      check("R9 gie cleared", flags_q, 8'hBC);
      wr(8'hFF, 8'h40);
      check("R10 before return", flags_q, 8'h4C);
      irq_return = 1; tick();
      check("R10 restored", flags_q, 8'hBD);
   endtask

   task automatic t_irq_prio();
      logic [7:0] d;
      wr(8'hFF, 8'h71);
      irq_enter = 1; wr(8'hCF, 8'hF0);
      rd(8'hCF, d); check("R11 save beats shadow write", d, 8'h71);
      irq_enter = 1; wr(8'hFF, 8'h01);
      check("R11 entry clears gie over write", flags_q, 8'h0C);
   endtask

   task automatic t_other();
      logic [7:0] d;
      rd(8'h10, d); check("R12 other addr", d, 8'h00);
      rd(8'hCE, d); check("R12 neighbour addr", d, 8'h00);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1; rst_n = 1;
      t_reset();
      t_alu();
      t_swwrite();
      t_priority();
      t_sticky();
      t_hold();
      t_irq();
      t_irq_prio();
      t_other();
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule